// File: doc/BRIEF.md
# Step Attenuator Control Interface

This block is the control logic that sets a 7-bit digital step attenuator. The step is 0.25 dB, so code 127 gives 31.75 dB. A mode pin picks how the state is written.

In parallel mode, seven control bits feed a transparent latch gated by the latch-enable line. A short high pulse on that line captures a value. Holding the line high makes the output follow the bits directly.

In serial mode, a 16-bit shift register fills least significant bit first on each rising edge of the serial clock while latch-enable is low. The serial clock is sampled on the system clock. The low byte of the frame is the attenuation word and the high byte is an address. A rising latch-enable applies the word only when the address equals the three strap pins, with every upper address bit zero.

A state machine tracks the interface. Its states are:
- BOOT: the single cycle after reset, in which nothing is written.
- PAR_HOLD: parallel mode with latch-enable low.
- PAR_TRACK: parallel mode with latch-enable high.
- SER_SHIFT: serial mode with latch-enable low.
- SER_LATCH: serial mode with latch-enable high.

From every state, the next state is chosen only by the present mode and latch-enable levels. Its actions depend on the transition taken:
- Entering or staying in PAR_TRACK loads the parallel bits.
- Entering SER_LATCH from any other state except BOOT tries a serial apply.
- Staying in SER_SHIFT allows shifting.

Top module: `step_atten_ctrl`

## Requirements
- R1: Reset sets the attenuation output to 0x7F (bit 7 clear, bits 6..0 set) and clears the address-miss flag; the value holds until a new word is written.
- R2: While latch-enable is low, the attenuation output does not change, whatever the parallel bits do.
- R3: In parallel mode (mode pin low) with latch-enable high, the output equals {0, parallel bits} one clock later and keeps following them. After latch-enable falls, the last value is kept.
- R4: In serial mode (mode pin high) with latch-enable low, each rising serial-clock edge shifts one data bit into the frame, least significant bit first. After 16 edges, bits 7..0 of the frame are the first eight bits sent and bits 15..8 are the last eight bits sent.
- R5: On a rising latch-enable in serial mode, if frame bits 15..8 equal {00000, strap pins}, the output takes frame bits 7..0, including bit 7, one clock later.
- R6: On a serial apply whose address byte differs in any bit, the output is left unchanged and the address-miss flag is set. A matching apply clears the flag.
- R7: Serial-clock edges while latch-enable is high, or while in parallel mode, do not alter the frame.
- R8: In serial mode the parallel bits have no effect on the output.
- R9: The first clock after reset release writes nothing. On the next clock, parallel mode with latch-enable high loads the parallel bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_serial | input | 1 | 0 = parallel interface, 1 = serial-addressable interface |
| par_bits | input | 7 | Parallel attenuation control bits |
| le | input | 1 | Latch enable |
| sclk | input | 1 | Serial clock, sampled on clk |
| sdata | input | 1 | Serial data |
| strap_addr | input | 3 | Static address strap pins |
| atten_q | output | 8 | Applied attenuation word (bits 6..0 are the step code) |
| addr_miss | output | 1 | Set when the last serial apply had a non-matching address |

## Verification
Every result of this block is due exactly one clock edge after the sampled input that causes it:
- a parallel load appears on the edge that sees latch-enable high;
- a serial apply and the miss flag appear on the edge that first sees latch-enable high;
- one frame bit shifts on the edge that first sees the serial clock high.

The bench changes inputs on falling edges and checks on the next falling edge, so exactly one rising edge lies between each stimulus and its check. The only exception is the check just after reset release: there the first edge is the BOOT cycle, so the bench checks both after that edge and after the one that follows.

// File: rtl/sac_pkg.sv
package sac_pkg;

    typedef enum logic [2:0] {
        S_BOOT      = 3'd0,
        S_PAR_HOLD  = 3'd1,
        S_PAR_TRACK = 3'd2,
        S_SER_SHIFT = 3'd3,
        S_SER_LATCH = 3'd4
    } sac_state_e;

endpackage

// File: rtl/sac_edge_det.sv
module sac_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic rise
);
    logic sig_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sig_prev <= 1'b0;
        else        sig_prev <= sig;
    end

    assign rise = sig & ~sig_prev;

    // R4: a detected edge cannot repeat on the next cycle without a low in between
    p_single_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/sac_shift.sv
module sac_shift #(
    parameter int FRAME_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               shift_en,
    input  logic               din,
    output logic [FRAME_W-1:0] frame
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        frame <= '0;
        else if (shift_en) frame <= {din, frame[FRAME_W-1:1]};
    end

    // R7: the frame is frozen whenever no shift is granted
    p_frame_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(frame));

    // R4: a granted shift places the new bit at the top of the frame
    p_shift_in_r4: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> frame[FRAME_W-1] == $past(din));
endmodule

// File: rtl/sac_addr_cmp.sv
module sac_addr_cmp #(
    parameter int WORD_W = 8,
    parameter int ADDR_W = 3
) (
    input  logic [WORD_W-1:0] addr_word,
    input  logic [ADDR_W-1:0] strap,
    output logic              match
);
    logic low_eq;
    logic high_zero;

    assign low_eq = (addr_word[ADDR_W-1:0] == strap);

    generate
        if (WORD_W > ADDR_W) begin : g_upper
            assign high_zero = ~|addr_word[WORD_W-1:ADDR_W];
        end else begin : g_no_upper
            assign high_zero = 1'b1;
        end
    endgenerate

    assign match = low_eq & high_zero;
endmodule

// File: rtl/sac_fsm.sv
module sac_fsm
    import sac_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_serial,
    input  logic       le,
    output sac_state_e state_q,
    output logic       load_par,
    output logic       load_ser,
    output logic       shift_ok
);
    sac_state_e state_d;
    sac_state_e level_state;

    // State selected by the present mode and latch-enable levels
    always_comb begin
        if (mode_serial) level_state = le ? S_SER_LATCH : S_SER_SHIFT;
        else             level_state = le ? S_PAR_TRACK : S_PAR_HOLD;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_BOOT;
        else        state_q <= state_d;
    end

    // Next state: every state leaves to the level-selected state
    always_comb begin
        unique case (state_q)
            S_BOOT:      state_d = level_state;
            S_PAR_HOLD:  state_d = level_state;
            S_PAR_TRACK: state_d = level_state;
            S_SER_SHIFT: state_d = level_state;
            S_SER_LATCH: state_d = level_state;
            default:     state_d = S_BOOT;
        endcase
    end

    // Actions per transition
    always_comb begin
        load_par = 1'b0;
        load_ser = 1'b0;
        shift_ok = 1'b0;
        unique case (state_q)
            S_BOOT: begin
                // no action in the first cycle after reset
            end
            S_PAR_HOLD, S_PAR_TRACK, S_SER_SHIFT: begin
                load_par = (state_d == S_PAR_TRACK);
                load_ser = (state_d == S_SER_LATCH);
                shift_ok = (state_d == S_SER_SHIFT);
            end
            S_SER_LATCH: begin
                load_par = (state_d == S_PAR_TRACK);
                shift_ok = (state_d == S_SER_SHIFT);
            end
            default: begin
            end
        endcase
    end

    // R9: boot lasts exactly one cycle
    p_boot_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == S_BOOT |=> state_q != S_BOOT);

    // R5: a serial apply is a single-cycle event
    p_ser_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load_ser |=> !load_ser);
endmodule

// File: rtl/step_atten_ctrl.sv
module step_atten_ctrl
    import sac_pkg::*;
#(
    parameter int STEP_W = 7,
    parameter int WORD_W = 8,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_serial,
    input  logic [STEP_W-1:0] par_bits,
    input  logic              le,
    input  logic              sclk,
    input  logic              sdata,
    input  logic [ADDR_W-1:0] strap_addr,
    output logic [WORD_W-1:0] atten_q,
    output logic              addr_miss
);
    localparam int FRAME_W = 2 * WORD_W;
    localparam int PAD_W   = WORD_W - STEP_W;
    localparam logic [WORD_W-1:0] MAX_CODE = {{PAD_W{1'b0}}, {STEP_W{1'b1}}};

    sac_state_e         fsm_state;
    logic               load_par;
    logic               load_ser;
    logic               shift_ok;
    logic               sclk_rise;
    logic [FRAME_W-1:0] frame;
    logic               addr_match;

    sac_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_serial(mode_serial),
        .le         (le),
        .state_q    (fsm_state),
        .load_par   (load_par),
        .load_ser   (load_ser),
        .shift_ok   (shift_ok)
    );

    sac_edge_det u_sclk_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .sig  (sclk),
        .rise (sclk_rise)
    );

    sac_shift #(.FRAME_W(FRAME_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_en(shift_ok & sclk_rise),
        .din     (sdata),
        .frame   (frame)
    );

    sac_addr_cmp #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_addr (
        .addr_word(frame[FRAME_W-1:WORD_W]),
        .strap    (strap_addr),
        .match    (addr_match)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            atten_q   <= MAX_CODE;
            addr_miss <= 1'b0;
        end else begin
            if (load_par) begin
                atten_q <= {{PAD_W{1'b0}}, par_bits};
            end else if (load_ser && addr_match) begin
                atten_q <= frame[WORD_W-1:0];
            end
            if (load_ser) addr_miss <= ~addr_match;
        end
    end

    // R2: latch-enable low means no change on the next edge
    p_hold_le_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !le |=> $stable(atten_q));

    // R3: parallel transparent tracking
    p_par_track_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_serial && le && fsm_state != S_BOOT)
        |=> atten_q == {{PAD_W{1'b0}}, $past(par_bits)});

    // R6: the miss flag only rises from a serial latch event
    p_miss_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(addr_miss) |-> $past(mode_serial && le));

    // R8: in serial mode a held latch-enable does not change the output
    p_ser_le_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_serial && le && $past(mode_serial && le)) |=> $stable(atten_q));
endmodule

// File: tb/step_atten_ctrl_test.sv
module step_atten_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_serial = 1'b1;
    logic [6:0] par_bits = '0;
    logic       le = 1'b0;
    logic       sclk = 1'b0;
    logic       sdata = 1'b0;
    logic [2:0] strap_addr = 3'd5;
    logic [7:0] atten_q;
    logic       addr_miss;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    localparam int NVEC = 8;
    localparam logic [6:0] PAR_VEC [NVEC] = '{7'h00, 7'h7F, 7'h55, 7'h2A,
                                              7'h01, 7'h40, 7'h33, 7'h6C};

    always #2 clk = ~clk;

    step_atten_ctrl uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_serial(mode_serial),
        .par_bits   (par_bits),
        .le         (le),
        .sclk       (sclk),
        .sdata      (sdata),
        .strap_addr (strap_addr),
        .atten_q    (atten_q),
        .addr_miss  (addr_miss)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d cycles expected=finish", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp_v);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic shift_frame(input logic [15:0] w);
        for (int i = 0; i < 16; i++) begin
            sdata = w[i];
            sclk = 1'b0;
            step();
            sclk = 1'b1;
            step();
        end
        sclk = 1'b0;
        step();
    endtask

    task automatic le_pulse();
        le = 1'b1;
        step();
        le = 1'b0;
        step();
    endtask

    initial begin
        step();
        step();
        check("R1 reset atten", atten_q, 8'h7F);
        check("R1 reset miss", {7'd0, addr_miss}, 8'h00);
        rst_n = 1'b1;
        step();
        step();
        check("R1 hold after reset", atten_q, 8'h7F);

        // R7/R2: output frozen mid-shift
        for (int i = 0; i < 8; i++) begin
            sdata = 1'b1; sclk = 1'b1; step(); sclk = 1'b0; step();
        end
        check("R2 no change while shifting", atten_q, 8'h7F);
        for (int i = 0; i < 8; i++) begin
            sdata = 1'b0; sclk = 1'b1; step(); sclk = 1'b0; step();
        end

        // R4/R5: matching address
        shift_frame({8'h05, 8'h15});
        check("R4 before latch", atten_q, 8'h7F);
        le = 1'b1;
        step();
        check("R5 matched apply", atten_q, 8'h15);
        check("R6 miss clear", {7'd0, addr_miss}, 8'h00);
        le = 1'b0;
        step();

        // R6: wrong address
        shift_frame({8'h03, 8'h40});
        le_pulse();
        check("R6 mismatch keeps", atten_q, 8'h15);
        check("R6 miss set", {7'd0, addr_miss}, 8'h01);

        // R6: upper address bit set
        shift_frame({8'h0D, 8'h22});
        le_pulse();
        check("R6 upper bits mismatch", atten_q, 8'h15);

        // R5: bit 7 stored
        shift_frame({8'h05, 8'h95});
        le_pulse();
        check("R5 bit7 stored", atten_q, 8'h95);
        check("R6 miss cleared by match", {7'd0, addr_miss}, 8'h00);

        // R7: sclk while le high does not disturb frame
        shift_frame({8'h05, 8'h22});
        le = 1'b1;
        step();
        check("R5 apply 22", atten_q, 8'h22);
        for (int i = 0; i < 8; i++) begin
            sdata = 1'b1; sclk = 1'b1; step(); sclk = 1'b0; step();
        end
        le = 1'b0;
        step();
        // R7: parallel-mode sclk edges ignored too
        mode_serial = 1'b0;
        par_bits = 7'h01;
        step();
        for (int i = 0; i < 4; i++) begin
            sdata = 1'b1; sclk = 1'b1; step(); sclk = 1'b0; step();
        end
        le_pulse();
        check("R3 parallel latch 01", atten_q, 8'h01);
        mode_serial = 1'b1;
        par_bits = 7'h55;
        step();
        le = 1'b1;
        step();
        check("R7 frame intact / R8 par ignored", atten_q, 8'h22);
        le = 1'b0;
        step();

        // Parallel vector table: R2 and R3
        mode_serial = 1'b0;
        step();
        for (int v = 0; v < NVEC; v++) begin
            logic [7:0] held;
            held = atten_q;
            par_bits = PAR_VEC[v];
            step();
            check("R2 le low ignores par", atten_q, held);
            le = 1'b1;
            step();
            check("R3 latch par", atten_q, {1'b0, PAR_VEC[v]});
            par_bits = ~PAR_VEC[v];
            step();
            check("R3 direct follows", atten_q, {1'b0, ~PAR_VEC[v]});
            le = 1'b0;
            step();
            par_bits = PAR_VEC[v];
            step();
            check("R3 held after fall", atten_q, {1'b0, ~PAR_VEC[v]});
        end

        // R9: power-up in direct parallel mode
        rst_n = 1'b0;
        mode_serial = 1'b0;
        le = 1'b1;
        par_bits = 7'h33;
        step();
        check("R1 reset again", atten_q, 8'h7F);
        rst_n = 1'b1;
        step();
        check("R9 boot cycle no write", atten_q, 8'h7F);
        step();
        check("R9 direct load after boot", atten_q, 8'h33);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule